// File: doc/BRIEF.md
# Double-Buffered Handshake Output Port

This block is a parallel output port that sits between a processor's register writes and an external peripheral. Bytes written by the processor enter a two-deep buffer. The first stage is an intake latch. The second stage is a pin latch that drives the output pins. A byte moves from the intake latch to the pin latch on the clock edge after the pin latch becomes free. The peripheral is told about new data on a strobe output, and it confirms that it has taken the data with a rising edge on an acknowledge input.

A small control register sets the behaviour of the port:
- Strobe protocol: in interlocked mode the strobe stays high until the peripheral acknowledges. In pulsed mode the strobe is a fixed-length pulse that a rising acknowledge edge cuts short at once.
- Status meaning: the room status bit reports either "at least one latch is free" or "both latches are empty".
- Service request: one bit gates both the interrupt request and the DMA request. These requests follow the room status.
- Enable: when the port is disabled the strobe is forced low. The buffer still accepts bytes while the port is disabled.

Top module: `hop_port`

## Requirements
- R1: After reset the pins read 0x00, the strobe is low, the room status is 1 (both latches empty), the second status bit is 0, and both the interrupt and DMA requests are low.
- R2: A byte written while both latches are empty appears on `pin_data` after the second rising clock edge that follows the write. In interlocked mode `pin_data` does not change while the strobe stays high.
- R3: A write made while both latches are full is discarded. The byte is never delivered, and the two bytes already held are delivered in order.
- R4: In interlocked mode (control bit 3 = 0) with the port enabled, the strobe is high while the pin latch holds undelivered data. The strobe goes low one edge after a rising acknowledge edge. A byte waiting in the intake latch reaches the pins on the following edge, and the strobe rises again.
- R5: In pulsed mode (control bit 3 = 1) the strobe rises one clock after the byte reaches the pins. It stays high for exactly PULSE_LEN cycles (4 by default) and then frees the pin latch.
- R6: In pulsed mode, a rising acknowledge edge during the pulse drives the strobe low in that same cycle, without waiting for a clock edge. The pulse ends and the pin latch is freed.
- R7: With control bit 4 = 0 (port disabled) the strobe stays low whatever the buffer holds, and both latches still accept writes.
- R8: With control bit 0 = 0, the room status is 1 unless both latches are full.
- R9: With control bit 0 = 1, the room status is 1 only when both latches are empty.
- R10: The second status bit always reads 0, so the strobe interrupt enable (control bit 2) never raises the interrupt request.
- R11: The interrupt request and the DMA request each equal the room status ANDed with control bit 1.
- R12: Only a rising acknowledge edge delivers data. An acknowledge held high does not deliver the next byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 5 | Control value: bit0 status select, bit1 service enable, bit2 strobe interrupt enable, bit3 pulsed mode, bit4 port enable |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 8 | Byte to buffer |
| ack_in | input | 1 | Peripheral acknowledge; the rising edge is active |
| pin_data | output | 8 | Pin latch contents |
| strobe_out | output | 1 | Data-available strobe to the peripheral |
| stat_room | output | 1 | Room status bit |
| stat_aux | output | 1 | Second status bit, always 0 |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
A lost or duplicated occupancy flag shows up at the ports within one or two clock edges. A lost flag drops a byte or leaves the strobe low when data is waiting. A duplicated flag makes the strobe rise a second time with the same byte, and it skews the room status at once in both status modes. A wrong pulse counter shows as a strobe that is one cycle too long or too short, or as a strobe that stays high in the cycle of an acknowledge edge. The bench sweeps every status mode, service enable, interrupt enable and fill level from 0 to 2. It then sends sequences of bytes through both protocols and compares every pin value and every strobe count against values it works out arithmetically.

// File: rtl/hop_pkg.sv
`timescale 1ns/1ps
// Package: shared control register layout for the handshake output port.
// Assumes: bit positions are fixed by the register write interface.
package hop_pkg;
    typedef struct packed {
        logic port_en;    // bit 4: strobe allowed
        logic pulsed;     // bit 3: 1 = pulsed strobe, 0 = interlocked
        logic aux_ie;     // bit 2: strobe interrupt enable
        logic svc_en;     // bit 1: interrupt and DMA request enable
        logic stat_sel;   // bit 0: room status meaning
    } hop_ctrl_t;

    localparam int CTRL_W = $bits(hop_ctrl_t);
endpackage

// File: rtl/hop_ctrl_reg.sv
`timescale 1ns/1ps
// Module: control register of the output port.
// Holds the mode bits written by the processor.
// Assumes: the mode is changed only while no transfer is in flight.
module hop_ctrl_reg
    import hop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output hop_ctrl_t         ctrl_q
);
    // Register the control value on a write; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we)
            ctrl_q <= hop_ctrl_t'(wdata);
    end
endmodule

// File: rtl/hop_buffer.sv
`timescale 1ns/1ps
// Module: two-stage output buffer (intake latch, then pin latch).
// Data moves forward on the edge after the pin latch is empty.
// No refill happens in the same edge as a consume, so every byte gets
// its own strobe. A write is dropped when both stages are full.
// Assumes: consume is asserted only while the pin latch is full.
module hop_buffer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              consume,
    output logic [DATA_W-1:0] pin_data,
    output logic              intake_full,
    output logic              pin_full
);
    localparam int STAGES = 2;

    logic [DATA_W-1:0] stage_data [STAGES];
    logic [STAGES-1:0] stage_full;
    logic              accept;
    logic              advance;

    // Decide write acceptance and forward movement from the current fill.
    always_comb begin
        accept  = wr_en && !(&stage_full);
        advance = stage_full[0] && !stage_full[1];
    end

    // Intake stage: load on accepted write, empty when its byte advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_data[0] <= '0;
            stage_full[0] <= 1'b0;
        end else if (accept) begin
            stage_data[0] <= wr_data;
            stage_full[0] <= 1'b1;
        end else if (advance) begin
            stage_full[0] <= 1'b0;
        end
    end

    // Pin stage: take the intake byte when empty, release on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_data[1] <= '0;
            stage_full[1] <= 1'b0;
        end else if (advance) begin
            stage_data[1] <= stage_data[0];
            stage_full[1] <= 1'b1;
        end else if (consume) begin
            stage_full[1] <= 1'b0;
        end
    end

    assign pin_data    = stage_data[1];
    assign intake_full = stage_full[0];
    assign pin_full    = stage_full[1];
endmodule

// File: rtl/hop_strobe.sv
`timescale 1ns/1ps
// Module: strobe generator and acknowledge edge detector.
// Interlocked: strobe follows pin latch occupancy, and a rising ack
// consumes the byte. Pulsed: a PULSE_LEN-cycle pulse starts one cycle
// after the byte lands; a rising ack kills it combinationally.
// Assumes: ack_in is already synchronous to clk.
module hop_strobe #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic pulsed,
    input  logic ack_in,
    input  logic pin_full,
    output logic strobe,
    output logic consume
);
    localparam int CNT_W = $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PULSE_LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic             ack_q;
    logic             ack_rise;
    logic [CNT_W-1:0] pulse_cnt;
    logic             pulse_on;

    // Remember the previous acknowledge level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ack_q <= 1'b0;
        else
            ack_q <= ack_in;
    end

    assign ack_rise = ack_in && !ack_q;
    assign pulse_on = (pulse_cnt != '0);

    // Pulse counter: load on waiting data, count down, clear on ack edge.
    always_ff @(posedge clk) begin
        if (!rst_n || !pulsed)
            pulse_cnt <= '0;
        else if (pulse_on) begin
            if (ack_rise || pulse_cnt == CNT_LAST)
                pulse_cnt <= '0;
            else
                pulse_cnt <= pulse_cnt - CNT_W'(1);
        end else if (port_en && pin_full)
            pulse_cnt <= CNT_LOAD;
    end

    // Combine mode, enable and handshake state into strobe and consume.
    always_comb begin
        if (pulsed) begin
            strobe  = port_en && pulse_on && !ack_rise;
            consume = pulse_on && (ack_rise || pulse_cnt == CNT_LAST);
        end else begin
            strobe  = port_en && pin_full;
            consume = port_en && pin_full && ack_rise;
        end
    end
endmodule

// File: rtl/hop_status.sv
`timescale 1ns/1ps
// Module: status bits and service requests.
// Room status reports either "some latch free" or "all latches empty".
// The second status bit is constant 0 for output transfers.
// Assumes: occupancy flags come straight from the buffer registers.
module hop_status (
    input  logic stat_sel,
    input  logic svc_en,
    input  logic aux_ie,
    input  logic intake_full,
    input  logic pin_full,
    output logic stat_room,
    output logic stat_aux,
    output logic irq,
    output logic dma_req
);
    // Derive status and requests from occupancy and control bits.
    always_comb begin
        if (stat_sel)
            stat_room = !intake_full && !pin_full;
        else
            stat_room = !(intake_full && pin_full);
        stat_aux = 1'b0;
        dma_req  = svc_en && stat_room;
        irq      = (svc_en && stat_room) || (aux_ie && stat_aux);
    end
endmodule

// File: rtl/hop_port.sv
`timescale 1ns/1ps
// Module: top of the double-buffered handshake output port.
// Wires the control register, two-stage buffer, strobe generator and
// status logic together.
// Assumes: a single clock domain and a synchronous active-low reset.
module hop_port
    import hop_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int PULSE_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              data_we,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              ack_in,
    output logic [DATA_W-1:0] pin_data,
    output logic              strobe_out,
    output logic              stat_room,
    output logic              stat_aux,
    output logic              irq,
    output logic              dma_req
);
    hop_ctrl_t ctrl_q;
    logic      intake_full;
    logic      pin_full;
    logic      consume;

    hop_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (ctrl_wdata),
        .ctrl_q (ctrl_q)
    );

    hop_buffer #(.DATA_W(DATA_W)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (data_we),
        .wr_data     (data_wdata),
        .consume     (consume),
        .pin_data    (pin_data),
        .intake_full (intake_full),
        .pin_full    (pin_full)
    );

    hop_strobe #(.PULSE_LEN(PULSE_LEN)) u_stb (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_en  (ctrl_q.port_en),
        .pulsed   (ctrl_q.pulsed),
        .ack_in   (ack_in),
        .pin_full (pin_full),
        .strobe   (strobe_out),
        .consume  (consume)
    );

    hop_status u_stat (
        .stat_sel    (ctrl_q.stat_sel),
        .svc_en      (ctrl_q.svc_en),
        .aux_ie      (ctrl_q.aux_ie),
        .intake_full (intake_full),
        .pin_full    (pin_full),
        .stat_room   (stat_room),
        .stat_aux    (stat_aux),
        .irq         (irq),
        .dma_req     (dma_req)
    );
endmodule

// File: rtl/hop_port_chk.sv
`timescale 1ns/1ps
// Module: property checker for hop_port, attached by bind.
// Assumes: PULSE_LEN matches the checked instance.
module hop_port_chk #(
    parameter int DATA_W    = 8,
    parameter int PULSE_LEN = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              port_en,
    input logic              pulsed,
    input logic              ack_in,
    input logic [DATA_W-1:0] pin_data,
    input logic              strobe_out,
    input logic              stat_room,
    input logic              stat_aux,
    input logic              irq,
    input logic              dma_req
);
    localparam int RUN_W = $clog2(PULSE_LEN + 2) + 1;

    logic [RUN_W-1:0] run_cnt;

    // Count consecutive strobe-high cycles in pulsed mode (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || !pulsed || !strobe_out)
            run_cnt <= '0;
        else if (run_cnt < RUN_W'(PULSE_LEN + 1))
            run_cnt <= run_cnt + RUN_W'(1);
    end

    assert_aux_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_aux == 1'b0);

    assert_strobe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |-> !strobe_out);

    assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pulsed && strobe_out) |-> (run_cnt < RUN_W'(PULSE_LEN)));

    assert_ack_cut_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulsed && ack_in && !$past(ack_in)) |-> !strobe_out);

    assert_pins_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulsed && !$past(pulsed) && strobe_out && $past(strobe_out))
            |-> $stable(pin_data));

    assert_req_room_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || dma_req) |-> stat_room);
endmodule

bind hop_port hop_port_chk #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (ctrl_q.port_en),
    .pulsed     (ctrl_q.pulsed),
    .ack_in     (ack_in),
    .pin_data   (pin_data),
    .strobe_out (strobe_out),
    .stat_room  (stat_room),
    .stat_aux   (stat_aux),
    .irq        (irq),
    .dma_req    (dma_req)
);

// File: tb/test_hop_port.sv
`timescale 1ns/1ps
module test_hop_port;
    localparam int DATA_W = 8;
    localparam int PULSE_LEN = 4;
    localparam logic [4:0] C_EN = 5'h10;
    localparam logic [4:0] C_PULSE = 5'h08;
    localparam logic [4:0] C_SVC = 5'h02;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_we = 1'b0;
    logic [4:0] ctrl_wdata = '0;
    logic data_we = 1'b0;
    logic [DATA_W-1:0] data_wdata = '0;
    logic ack_in = 1'b0;
    logic [DATA_W-1:0] pin_data;
    logic strobe_out, stat_room, stat_aux, irq, dma_req;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hop_port #(.DATA_W(DATA_W), .PULSE_LEN(PULSE_LEN)) i_hop_port (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .ack_in(ack_in),
        .pin_data(pin_data), .strobe_out(strobe_out), .stat_room(stat_room),
        .stat_aux(stat_aux), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ctrl_we = 1'b0; data_we = 1'b0; ack_in = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        step();
        ctrl_we = 1'b0;
    endtask

    task automatic wr_data(input logic [7:0] v);
        data_we = 1'b1; data_wdata = v;
        step();
        data_we = 1'b0;
    endtask

    task automatic ack_pulse();
        ack_in = 1'b1;
        step();
        ack_in = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic exp_room;
        logic [7:0] b;
        int hi;
        do_reset();

        // R1: reset state
        chk("R1 pin", pin_data, 8'h00);
        chk("R1 strobe", strobe_out, 1'b0);
        chk("R1 room", stat_room, 1'b1);
        chk("R1 aux", stat_aux, 1'b0);
        chk("R1 irq", irq, 1'b0);
        chk("R1 dma", dma_req, 1'b0);

        // R8 R9 R10 R11: sweep status select, service, strobe irq enable, fill 0..2
        for (int sel = 0; sel < 2; sel++)
            for (int svc = 0; svc < 2; svc++)
                for (int ie = 0; ie < 2; ie++)
                    for (int occ = 0; occ < 3; occ++) begin
                        do_reset();
                        wr_ctrl({1'b0, 1'b0, ie[0], svc[0], sel[0]});
                        for (int k = 0; k < occ; k++) wr_data(8'(k + 1));
                        step();
                        exp_room = (sel != 0) ? (occ == 0) : (occ < 2);
                        chk(sel != 0 ? "R9 room" : "R8 room", stat_room, exp_room);
                        chk("R11 irq", irq, exp_room & svc[0]);
                        chk("R11 dma", dma_req, exp_room & svc[0]);
                        chk("R10 aux", stat_aux, 1'b0);
                    end

        // R7 R3: disabled port fills, third write dropped
        do_reset();
        wr_ctrl(C_SVC);
        wr_data(8'hA5);
        wr_data(8'h3C);
        step();
        wr_data(8'hC3);
        step();
        chk("R7 strobe held low", strobe_out, 1'b0);
        chk("R7 pin filled", pin_data, 8'hA5);
        chk("R8 room full", stat_room, 1'b0);
        wr_ctrl(C_EN | C_SVC);
        chk("R4 strobe on enable", strobe_out, 1'b1);
        ack_pulse();
        chk("R4 strobe drop", strobe_out, 1'b0);
        step();
        chk("R3 second byte", pin_data, 8'h3C);
        chk("R4 strobe again", strobe_out, 1'b1);
        ack_pulse();
        step(); step();
        chk("R3 dropped byte absent", pin_data, 8'h3C);
        chk("R3 strobe idle", strobe_out, 1'b0);
        chk("R8 room empty", stat_room, 1'b1);

        // R12: held acknowledge delivers only one byte
        do_reset();
        wr_ctrl(C_EN);
        wr_data(8'h11);
        wr_data(8'h22);
        chk("R12 first", pin_data, 8'h11);
        ack_in = 1'b1;
        step(); step(); step(); step();
        chk("R12 next held", pin_data, 8'h22);
        chk("R12 strobe held", strobe_out, 1'b1);
        ack_in = 1'b0;
        step();
        ack_pulse();
        step();
        chk("R12 done", strobe_out, 1'b0);

        // R2 R4: interlocked sweep
        do_reset();
        wr_ctrl(C_EN);
        for (int i = 0; i < 16; i++) begin
            b = 8'(i * 17) ^ 8'h5A;
            wr_data(b);
            step();
            chk("R2 pin", pin_data, b);
            chk("R4 strobe high", strobe_out, 1'b1);
            step(); step();
            chk("R2 pin held", pin_data, b);
            ack_pulse();
            chk("R4 strobe low", strobe_out, 1'b0);
        end

        // R5: pulsed sweep
        do_reset();
        wr_ctrl(C_EN | C_PULSE);
        for (int i = 0; i < 8; i++) begin
            b = 8'(i * 29 + 3);
            wr_data(b);
            step();
            chk("R5 pin", pin_data, b);
            chk("R5 strobe delayed", strobe_out, 1'b0);
            hi = 0;
            for (int c = 0; c < 8; c++) begin
                step();
                if (strobe_out) hi++;
            end
            chk("R5 pulse length", 32'(hi), 32'(PULSE_LEN));
        end

        // R6: acknowledge cuts the pulse
        wr_data(8'h77);
        step(); step(); step();
        chk("R6 pulse on", strobe_out, 1'b1);
        ack_in = 1'b1;
        #1;
        chk("R6 immediate drop", strobe_out, 1'b0);
        step();
        ack_in = 1'b0;
        chk("R6 stays low", strobe_out, 1'b0);
        step();
        chk("R6 ended", strobe_out, 1'b0);
        wr_data(8'h88);
        step(); step();
        chk("R6 latch freed", pin_data, 8'h88);
        chk("R6 new pulse", strobe_out, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule